// File: doc/BRIEF.md
# Trapping Integer Arithmetic Unit

This block is the integer execute unit of a 64-bit RISC core. It adds and subtracts quadwords (64 bits) and longwords (32 bits), and each of these has a plain form and a form that checks for signed overflow. It also multiplies: a signed 32-bit multiply with overflow check, a 64-bit multiply with overflow check, and an unsigned multiply that returns the upper half of the product. Three bit-counting operations complete the set: population count, leading-zero count and trailing-zero count.

The core presents an opcode and two operands together with a one-cycle `start`. The unit accepts `start` only in its idle state. Non-multiply operations pass through an execute state. Multiplies go through a four-step state in which one 32x32 partial product is accumulated per cycle. Both paths end in a done state that pulses `done` for one cycle. When a trapping opcode overflows, `trap` pulses in that same cycle and `trap_code` carries the fixed overflow code. Exception handling and register writeback happen outside this unit.

FSM states: IDLE (waits for start), EXEC (computes add, subtract and count results), MUL (four accumulate steps), DONE (presents the result). Transitions: IDLE to EXEC on start with a non-multiply opcode; IDLE to MUL on start with a multiply opcode; EXEC to DONE always; MUL to DONE after the fourth step; DONE to IDLE always.

Top module: `int_trap_alu`

## Requirements
- R1: Opcode 0 (quad add) returns opa + opb modulo 2^64. Opcode 4 (quad subtract) returns opa - opb modulo 2^64.
- R2: Opcode 1 (quad add, trapping) returns the same result as opcode 0. It traps when opa[63] equals opb[63] and the sum's bit 63 differs from them.
- R3: Longword opcodes 2 (add), 3 (add, trapping), 6 (subtract) and 7 (subtract, trapping) use only bits 31:0 of the operands. They return the 32-bit result sign-extended from bit 31. Opcode 3 traps on the same-sign/different-result rule applied at bit 31.
- R4: Opcode 5 (quad subtract, trapping) traps when opa[63] differs from opb[63] and the result's bit 63 differs from opa[63].
- R5: Opcode 7 traps when opa[31] differs from opb[31] and the result's bit 31 differs from opa[31].
- R6: Opcodes 0, 2, 4 and 6 never assert trap, whatever the operands.
- R7: Opcode 8 multiplies opa[31:0] and opb[31:0] as signed values. It returns the low 32 bits of the product sign-extended, and traps when the product does not fit in a signed 32-bit value.
- R8: Opcode 9 returns the low 64 bits of the unsigned 128-bit product, and traps when the upper 64 bits are nonzero.
- R9: Opcode 10 returns the upper 64 bits of the unsigned 128-bit product and never traps.
- R10: Opcode 11 returns the number of set bits in opa.
- R11: Opcode 12 returns the number of leading zeros of opa and opcode 13 the number of trailing zeros. Both return 64 for a zero operand.
- R12: trap pulses only together with done. While trap is high, trap_code is 8'h01; otherwise trap_code is 0.
- R13: done is high for exactly one cycle per accepted operation. A start that arrives while an operation is in progress is ignored.
- R14: After reset, result is 0 and done and trap are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted in IDLE only) |
| opcode | input | 4 | Operation select |
| opa | input | 64 | First operand (minuend) |
| opb | input | 64 | Second operand |
| result | output | 64 | Result of the last completed operation |
| done | output | 1 | One-cycle pulse when result is valid |
| trap | output | 1 | Overflow trap pulse |
| trap_code | output | 8 | Arithmetic-overflow code while trap is high |

## Verification
The bench targets the sign-boundary operands: most-positive plus one, most-negative minus one, zero minus most-negative, and most-negative plus most-negative. A wrong overflow formula either misses these traps or fires on the plain opcodes. Longword cases carry garbage in the upper operand bits. A unit that forgets to mask those bits, or to sign-extend the result, returns wrong upper words. The multiply cases use all-ones operands and values just past 2^31, which expose a carry dropped between partial products or a signed-range test that is off by one. The bench also counts zero and single-bit operands, issues a second start during a multiply, and checks that done pulses only once. An off-by-one narrowing step, or a unit that accepts the second start, shows up as a wrong count or a second result.

// File: rtl/iat_pkg.sv
package iat_pkg;

    typedef enum logic [3:0] {
        OP_ADDQ  = 4'd0,
        OP_ADDQV = 4'd1,
        OP_ADDL  = 4'd2,
        OP_ADDLV = 4'd3,
        OP_SUBQ  = 4'd4,
        OP_SUBQV = 4'd5,
        OP_SUBL  = 4'd6,
        OP_SUBLV = 4'd7,
        OP_MULLV = 4'd8,
        OP_MULQV = 4'd9,
        OP_UMULH = 4'd10,
        OP_POPC  = 4'd11,
        OP_CLZ   = 4'd12,
        OP_CTZ   = 4'd13
    } iat_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EXEC,
        S_MUL,
        S_DONE
    } iat_state_e;

    localparam logic [7:0] OVF_CODE = 8'h01;

    function automatic logic op_traps(input logic [3:0] op);
        return (op == OP_ADDQV) || (op == OP_ADDLV) ||
               (op == OP_SUBQV) || (op == OP_SUBLV);
    endfunction

    function automatic logic op_is_mul(input logic [3:0] op);
        return (op == OP_MULLV) || (op == OP_MULQV) || (op == OP_UMULH);
    endfunction

    function automatic logic op_is_long(input logic [3:0] op);
        return (op == OP_ADDL) || (op == OP_ADDLV) ||
               (op == OP_SUBL) || (op == OP_SUBLV);
    endfunction

    function automatic logic op_is_sub(input logic [3:0] op);
        return (op == OP_SUBQ) || (op == OP_SUBQV) ||
               (op == OP_SUBL) || (op == OP_SUBLV);
    endfunction

endpackage

// File: rtl/iat_addsub.sv
module iat_addsub #(
    parameter int WORD = 64
) (
    input  logic [WORD-1:0] a,
    input  logic [WORD-1:0] b,
    input  logic            sub,
    input  logic            long_mode,
    output logic [WORD-1:0] sum,
    output logic            ovf
);
    localparam int HALF = WORD / 2;

    logic [WORD-1:0] quad_r;
    logic [HALF-1:0] long_r;
    logic            sign_a, sign_b, sign_r;

    always_comb begin
        quad_r = sub ? (a - b) : (a + b);
        long_r = sub ? (a[HALF-1:0] - b[HALF-1:0]) : (a[HALF-1:0] + b[HALF-1:0]);
        if (long_mode) begin
            sum    = {{HALF{long_r[HALF-1]}}, long_r};
            sign_a = a[HALF-1];
            sign_b = b[HALF-1];
            sign_r = long_r[HALF-1];
        end else begin
            sum    = quad_r;
            sign_a = a[WORD-1];
            sign_b = b[WORD-1];
            sign_r = quad_r[WORD-1];
        end
        // add: like signs, result sign flips; sub: unlike signs, result leaves minuend sign
        if (sub) ovf = (sign_a != sign_b) && (sign_r != sign_a);
        else     ovf = (sign_a == sign_b) && (sign_r != sign_a);
    end
endmodule

// File: rtl/iat_bitcount.sv
module iat_bitcount #(
    parameter int WORD = 64,
    parameter int CW   = $clog2(WORD) + 1
) (
    input  logic [WORD-1:0] x,
    output logic [CW-1:0]   popc,
    output logic [CW-1:0]   lz,
    output logic [CW-1:0]   tz
);
    localparam int LOG2 = $clog2(WORD);

    logic [WORD-1:0] vl, vt;

    always_comb begin
        popc = '0;
        for (int i = 0; i < WORD; i++) popc = popc + CW'(x[i]);
    end

    // binary narrowing: halve the window each step (32,16,8,4,2,1 for 64 bits)
    always_comb begin
        lz = '0;
        tz = '0;
        vl = x;
        vt = x;
        if (x == '0) begin
            lz = CW'(WORD);
            tz = CW'(WORD);
        end else begin
            for (int s = LOG2 - 1; s >= 0; s--) begin
                if ((vl >> (WORD - (1 << s))) == '0) begin
                    lz = lz + CW'(1 << s);
                    vl = vl << (1 << s);
                end
                if ((vt << (WORD - (1 << s))) == '0) begin
                    tz = tz + CW'(1 << s);
                    vt = vt >> (1 << s);
                end
            end
        end
    end
endmodule

// File: rtl/iat_mul_acc.sv
module iat_mul_acc #(
    parameter int WORD = 64
) (
    input  logic [2*WORD-1:0] acc,
    input  logic [WORD-1:0]   a,
    input  logic [WORD-1:0]   b,
    input  logic [1:0]        step,
    output logic [2*WORD-1:0] acc_next
);
    localparam int HALF = WORD / 2;

    logic [HALF-1:0]   xa, yb;
    logic [WORD-1:0]   pp;
    logic [2*WORD-1:0] pp_ext;

    always_comb begin
        case (step)
            2'd0:    begin xa = a[HALF-1:0];    yb = b[HALF-1:0];    end
            2'd1:    begin xa = a[HALF-1:0];    yb = b[WORD-1:HALF]; end
            2'd2:    begin xa = a[WORD-1:HALF]; yb = b[HALF-1:0];    end
            default: begin xa = a[WORD-1:HALF]; yb = b[WORD-1:HALF]; end
        endcase
        pp = WORD'(xa) * WORD'(yb);
        case (step)
            2'd0:         pp_ext = {{WORD{1'b0}}, pp};
            2'd1, 2'd2:   pp_ext = {{HALF{1'b0}}, pp, {HALF{1'b0}}};
            default:      pp_ext = {pp, {WORD{1'b0}}};
        endcase
        acc_next = acc + pp_ext;
    end
endmodule

// File: rtl/int_trap_alu.sv
module int_trap_alu
    import iat_pkg::*;
#(
    parameter int WORD = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3:0]      opcode,
    input  logic [WORD-1:0] opa,
    input  logic [WORD-1:0] opb,
    output logic [WORD-1:0] result,
    output logic            done,
    output logic            trap,
    output logic [7:0]      trap_code
);
    localparam int HALF   = WORD / 2;
    localparam int CW     = $clog2(WORD) + 1;
    localparam int MSTEPS = 4;
    localparam int SW     = $clog2(MSTEPS);

    iat_state_e        state_q, state_d;
    logic [3:0]        op_q;
    logic [WORD-1:0]   a_q, b_q, res_q;
    logic [2*WORD-1:0] acc_q, acc_nx;
    logic [SW-1:0]     cnt_q;
    logic              ovf_q;

    logic [WORD-1:0]   as_sum, ex_res, mul_res;
    logic              as_ovf, ex_ovf, mul_ovf;
    logic [CW-1:0]     n_pop, n_lz, n_tz;

    iat_addsub #(.WORD(WORD)) u_addsub (
        .a(a_q), .b(b_q), .sub(op_is_sub(op_q)), .long_mode(op_is_long(op_q)),
        .sum(as_sum), .ovf(as_ovf)
    );

    iat_bitcount #(.WORD(WORD), .CW(CW)) u_count (
        .x(a_q), .popc(n_pop), .lz(n_lz), .tz(n_tz)
    );

    iat_mul_acc #(.WORD(WORD)) u_mul (
        .acc(acc_q), .a(a_q), .b(b_q), .step(cnt_q), .acc_next(acc_nx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = op_is_mul(opcode) ? S_MUL : S_EXEC;
            S_EXEC: state_d = S_DONE;
            S_MUL:  if (cnt_q == SW'(MSTEPS - 1)) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // single-cycle result selection
    always_comb begin
        ex_res = '0;
        ex_ovf = 1'b0;
        case (op_q)
            OP_ADDQ, OP_ADDQV, OP_ADDL, OP_ADDLV,
            OP_SUBQ, OP_SUBQV, OP_SUBL, OP_SUBLV: begin
                ex_res = as_sum;
                ex_ovf = as_ovf && op_traps(op_q);
            end
            OP_POPC: ex_res = WORD'(n_pop);
            OP_CLZ:  ex_res = WORD'(n_lz);
            OP_CTZ:  ex_res = WORD'(n_tz);
            default: ex_res = '0;
        endcase
    end

    // multiply finish: selects from the completed 128-bit product
    always_comb begin
        mul_res = '0;
        mul_ovf = 1'b0;
        case (op_q)
            OP_MULLV: begin
                mul_res = {{HALF{acc_nx[HALF-1]}}, acc_nx[HALF-1:0]};
                mul_ovf = !((acc_nx[WORD-1:HALF-1] == '0) || (acc_nx[WORD-1:HALF-1] == '1));
            end
            OP_MULQV: begin
                mul_res = acc_nx[WORD-1:0];
                mul_ovf = |acc_nx[2*WORD-1:WORD];
            end
            OP_UMULH: mul_res = acc_nx[2*WORD-1:WORD];
            default:  mul_res = '0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            acc_q <= '0;
            cnt_q <= '0;
            res_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    op_q  <= opcode;
                    acc_q <= '0;
                    cnt_q <= '0;
                    if (opcode == OP_MULLV) begin
                        // signed longword: sign-extend so the unsigned array yields the signed product
                        a_q <= {{HALF{opa[HALF-1]}}, opa[HALF-1:0]};
                        b_q <= {{HALF{opb[HALF-1]}}, opb[HALF-1:0]};
                    end else begin
                        a_q <= opa;
                        b_q <= opb;
                    end
                end
                S_EXEC: begin
                    res_q <= ex_res;
                    ovf_q <= ex_ovf;
                end
                S_MUL: begin
                    acc_q <= acc_nx;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == SW'(MSTEPS - 1)) begin
                        res_q <= mul_res;
                        ovf_q <= mul_ovf;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        result    = res_q;
        done      = (state_q == S_DONE);
        trap      = (state_q == S_DONE) && ovf_q;
        trap_code = trap ? OVF_CODE : 8'h00;
    end

    // R13: done is a single-cycle pulse
    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: captured operation is held while busy
    a_r13_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC || state_q == S_MUL) |=> ($stable(op_q) && $stable(a_q) && $stable(b_q)));

    // R12: trap only accompanies done
    a_r12_trap_done: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> done);

    // R6: plain add/sub never trap
    a_r6_no_trap_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_is_long(op_q) || op_is_sub(op_q) || op_q == OP_ADDQ) && !op_traps(op_q)) |-> !trap);

    // R3: longword results are sign-extended
    a_r3_long_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_is_long(op_q)) |-> (result[WORD-1:HALF] == {HALF{result[HALF-1]}}));

    // R11: counts never exceed the word width
    a_r11_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_CLZ || op_q == OP_CTZ || op_q == OP_POPC)) |-> (result <= WORD));

    // R9: multiply-high never traps
    a_r9_umulh_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_UMULH) |-> !trap);
endmodule

// File: tb/int_trap_alu_tb.sv
module int_trap_alu_tb;
    import iat_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  opcode = '0;
    logic [63:0] opa = '0, opb = '0;
    logic [63:0] result;
    logic        done, trap;
    logic [7:0]  trap_code;

    int total = 0;
    int fails = 0;

    logic [63:0] g_res;
    logic        g_trap;
    logic [7:0]  g_code;

    always #10 clk = ~clk;  // 50 MHz

    int_trap_alu u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .opa(opa), .opb(opb), .result(result), .done(done),
        .trap(trap), .trap_code(trap_code)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // independent reference model: {trap, result}
    function automatic logic [64:0] model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [64:0]  s65;
        logic [32:0]  s33;
        logic [127:0] p128;
        longint       pa, pb, pl;
        logic [63:0]  r;
        logic         v;
        int           n;
        r = '0; v = 1'b0;
        case (op)
            OP_ADDQ, OP_ADDQV: begin s65 = {a[63], a} + {b[63], b}; r = s65[63:0]; v = s65[64] ^ s65[63]; end
            OP_SUBQ, OP_SUBQV: begin s65 = {a[63], a} - {b[63], b}; r = s65[63:0]; v = s65[64] ^ s65[63]; end
            OP_ADDL, OP_ADDLV: begin s33 = {a[31], a[31:0]} + {b[31], b[31:0]}; r = {{32{s33[31]}}, s33[31:0]}; v = s33[32] ^ s33[31]; end
            OP_SUBL, OP_SUBLV: begin s33 = {a[31], a[31:0]} - {b[31], b[31:0]}; r = {{32{s33[31]}}, s33[31:0]}; v = s33[32] ^ s33[31]; end
            OP_MULLV: begin
                pa = longint'($signed(a[31:0])); pb = longint'($signed(b[31:0])); pl = pa * pb;
                r = {{32{pl[31]}}, pl[31:0]};
                v = (pl != longint'($signed(pl[31:0])));
            end
            OP_MULQV: begin p128 = {64'b0, a} * {64'b0, b}; r = p128[63:0]; v = |p128[127:64]; end
            OP_UMULH: begin p128 = {64'b0, a} * {64'b0, b}; r = p128[127:64]; end
            OP_POPC:  r = 64'($countones(a));
            OP_CLZ: begin n = 0; while (n < 64 && !a[63-n]) n++; r = 64'(n); end
            OP_CTZ: begin n = 0; while (n < 64 && !a[n]) n++; r = 64'(n); end
            default: r = '0;
        endcase
        if (!(op == OP_ADDQV || op == OP_ADDLV || op == OP_SUBQV || op == OP_SUBLV ||
              op == OP_MULLV || op == OP_MULQV)) v = 1'b0;
        return {v, r};
    endfunction

    task automatic run_op(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        int n;
        @(negedge clk);
        start = 1'b1; opcode = op; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 50) begin @(negedge clk); n++; end
        g_res = result; g_trap = trap; g_code = trap_code;
    endtask

    task automatic check_op(input string tag, input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [64:0] e;
        e = model(op, a, b);
        run_op(op, a, b);
        chk(tag, "result", g_res, e[63:0]);
        chk(tag, "trap", 64'(g_trap), 64'(e[64]));
        chk("R12", "trap_code", 64'(g_code), e[64] ? 64'(OVF_CODE) : 64'h0);
    endtask

    task automatic t_reset;
        chk("R14", "result after reset", result, 64'h0);
        chk("R14", "done after reset", 64'(done), 64'h0);
        chk("R14", "trap after reset", 64'(trap), 64'h0);
    endtask

    task automatic t_quad_add;
        check_op("R1", OP_ADDQ, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3211);
        run_op(OP_ADDQV, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
        chk("R2", "most-positive+1 result", g_res, 64'h8000_0000_0000_0000);
        chk("R2", "most-positive+1 trap", 64'(g_trap), 64'h1);
        check_op("R2", OP_ADDQV, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        check_op("R2", OP_ADDQV, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        check_op("R2", OP_ADDQV, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_long;
        run_op(OP_ADDLV, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_0000_0001);
        chk("R3", "long add sign-extended", g_res, 64'hFFFF_FFFF_8000_0000);
        chk("R3", "long add trap", 64'(g_trap), 64'h1);
        check_op("R3", OP_ADDLV, 64'hAAAA_0000_0000_0005, 64'h5555_0000_FFFF_FFFD);
        check_op("R3", OP_SUBL, 64'hFFFF_0000_0000_0003, 64'h0000_1111_0000_0005);
        run_op(OP_SUBLV, 64'h0000_0000_8000_0000, 64'h1);
        chk("R5", "long sub result", g_res, 64'h0000_0000_7FFF_FFFF);
        chk("R5", "long sub trap", 64'(g_trap), 64'h1);
        check_op("R5", OP_SUBLV, 64'h0, 64'h0000_0000_8000_0000);
        check_op("R5", OP_SUBLV, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000);
    endtask

    task automatic t_quad_sub;
        check_op("R1", OP_SUBQ, 64'h1, 64'h2);
        run_op(OP_SUBQV, 64'h8000_0000_0000_0000, 64'h1);
        chk("R4", "most-negative-1 result", g_res, 64'h7FFF_FFFF_FFFF_FFFF);
        chk("R4", "most-negative-1 trap", 64'(g_trap), 64'h1);
        check_op("R4", OP_SUBQV, 64'h0, 64'h8000_0000_0000_0000);
        check_op("R4", OP_SUBQV, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_plain_no_trap;
        run_op(OP_ADDQ, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
        chk("R6", "plain quad add trap", 64'(g_trap), 64'h0);
        chk("R6", "plain quad add result", g_res, 64'h8000_0000_0000_0000);
        check_op("R6", OP_SUBQ, 64'h8000_0000_0000_0000, 64'h1);
        check_op("R6", OP_ADDL, 64'h0000_0000_7FFF_FFFF, 64'h1);
        check_op("R6", OP_SUBL, 64'h0000_0000_8000_0000, 64'h1);
    endtask

    task automatic t_mul;
        check_op("R7", OP_MULLV, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0000_0000_0000_0007);
        check_op("R7", OP_MULLV, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000);
        check_op("R7", OP_MULLV, 64'h0000_0000_0001_0000, 64'hFFFF_FFFF_FFFF_8000);
        check_op("R7", OP_MULLV, 64'h1234_0000_0000_0003, 64'h0000_0000_2AAA_AAAB);
        check_op("R8", OP_MULQV, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);
        check_op("R8", OP_MULQV, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000);
        check_op("R9", OP_UMULH, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op(OP_UMULH, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R9", "all-ones high", g_res, 64'hFFFF_FFFF_FFFF_FFFE);
        check_op("R9", OP_UMULH, 64'h8765_4321_0FED_CBA9, 64'h1357_9BDF_2468_ACE0);
    endtask

    task automatic t_count;
        check_op("R10", OP_POPC, 64'h0, 64'h0);
        check_op("R10", OP_POPC, 64'hF0F0_0000_0000_0001, 64'h0);
        check_op("R10", OP_POPC, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        run_op(OP_CLZ, 64'h0, 64'h0);
        chk("R11", "clz of zero", g_res, 64'd64);
        run_op(OP_CTZ, 64'h0, 64'h0);
        chk("R11", "ctz of zero", g_res, 64'd64);
        check_op("R11", OP_CLZ, 64'h0000_0000_0000_0001, 64'h0);
        check_op("R11", OP_CLZ, 64'h8000_0000_0000_0000, 64'h0);
        check_op("R11", OP_CLZ, 64'h0000_0000_0010_0000, 64'h0);
        check_op("R11", OP_CTZ, 64'h8000_0000_0000_0000, 64'h0);
        check_op("R11", OP_CTZ, 64'h0000_0A00_0000_0000, 64'h0);
    endtask

    task automatic t_busy;
        logic [64:0] e;
        int          dones;
        e = model(OP_UMULH, 64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF);
        @(negedge clk);
        start = 1'b1; opcode = OP_UMULH; opa = 64'hFFFF_0000_FFFF_0000; opb = 64'h0000_FFFF_0000_FFFF;
        @(negedge clk);
        start = 1'b1; opcode = OP_ADDQ; opa = 64'h5; opb = 64'h6;  // arrives while busy
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        for (int i = 0; i < 12; i++) begin
            if (done) begin
                dones++;
                g_res = result;
            end
            @(negedge clk);
        end
        chk("R13", "done pulses while busy start", 64'(dones), 64'h1);
        chk("R13", "result ignores busy start", g_res, e[63:0]);
        run_op(OP_ADDQ, 64'h5, 64'h6);
        @(negedge clk);
        chk("R13", "done low after pulse", 64'(done), 64'h0);
        chk("R12", "trap low without done", 64'(trap), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_quad_add();
        t_long();
        t_quad_sub();
        t_plain_no_trap();
        t_mul();
        t_count();
        t_busy();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule